// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects a parameterized number of external interrupt lines, up to 240, and offers one of them at a time to a processor core. Each line is configured on its own. It can detect a rising edge or follow the line's level. It can be enabled or masked. It has a priority value. A line that is pending and enabled, and that is not already being serviced, is eligible. The controller picks the most urgent eligible line and presents the line's number, its priority and the matching exception number to the core. Lines are numbered from 0, and the exception number is the line number plus 16.

The core accepts the presented interrupt with a one-cycle acknowledge. That line then becomes active and is not offered again. For an edge-sensed line, the acknowledge also consumes the latched pending bit. When the handler finishes, the core pulses a completion strobe together with the line number, and the line becomes inactive again. A level-sensed line whose input is still high is then offered again.

Configuration is a single write port. Each write sets the enable, the sensing mode and the priority of one line at the same time.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every line is masked, edge-sensed (`cfg_level`=0), priority 0, not pending and not active, and `req_valid` is 0.
- R2: An edge-sensed line latches pending on a 0-to-1 transition of its input, which is seen one clock later. The bit stays set after the input falls and is cleared by the acknowledge of that line.
- R3: A level-sensed line (`cfg_level`=1) is pending exactly while its input, registered once, is 1. No latch is kept.
- R4: A masked line (`cfg_en`=0) still latches pending, but it is requested only while it is enabled. A line that becomes enabled while pending is requested in the cycle after the write.
- R5: Among eligible lines, the one with the numerically lowest 3-bit priority is presented, and `req_prio` carries that value.
- R6: When two or more eligible lines share the lowest priority, the lowest line number wins.
- R7: `req_exc` equals `req_id` + 16 whenever `req_valid` is 1.
- R8: An acknowledge (`ack`=1 while `req_valid`=1) makes the presented line active. An active line is never requested until `done` is pulsed with its number in `done_id`. A level-sensed line that is still high is requested again in the cycle after that completion.
- R9: If an edge-sensed line sees a new rising edge in the same cycle that it is acknowledged, the new edge wins. Its pending bit stays set, and the line is requested again after completion.
- R10: A `done` strobe naming a line that is not active has no effect on pending state or requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_IRQ | Interrupt input lines |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDW | Line number being configured |
| cfg_en | input | 1 | Enable (1) or mask (0) for the line |
| cfg_level | input | 1 | 1 = level sensing, 0 = rising-edge sensing |
| cfg_prio | input | PW | Priority value, lower is more urgent |
| req_valid | output | 1 | An interrupt is presented |
| req_id | output | IDW | Presented line number |
| req_prio | output | PW | Priority of the presented line |
| req_exc | output | 8 | Exception number, line number + 16 |
| ack | input | 1 | Core accepts the presented interrupt |
| done | input | 1 | Handler completion strobe |
| done_id | input | IDW | Line number being completed |

## Verification
Two events can coincide on the same edge-sensed line: its acknowledge clears the latched pending bit, and a fresh rising edge sets that bit. The bench arranges this by raising the input of the presented line in the same cycle that `ack` is driven. It then checks three things: no request appears while the line is active, the line is requested again right after its completion, and a second acknowledge and completion leave the controller idle. A related collision is a completion that names a line which is merely pending. Here the bench checks that the request stays exactly as it was.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NUM_IRQ = 24,
  parameter int PW = 3,
  localparam int IDW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               cfg_we,
  input  logic [IDW-1:0]     cfg_idx,
  input  logic               cfg_en,
  input  logic               cfg_level,
  input  logic [PW-1:0]      cfg_prio,
  output logic               req_valid,
  output logic [IDW-1:0]     req_id,
  output logic [PW-1:0]      req_prio,
  output logic [7:0]         req_exc,
  input  logic               ack,
  input  logic               done,
  input  logic [IDW-1:0]     done_id
);

  if (NUM_IRQ < 1 || NUM_IRQ > 240) begin : g_bad_cfg
    $error("NUM_IRQ must lie between 1 and 240");
  end

  logic [NUM_IRQ-1:0]    line_q, pend_q, en_q, lvl_q, act_q;
  logic [NUM_IRQ*PW-1:0] prio_q;

  logic [NUM_IRQ-1:0] rise, pend, elig, ack_set, done_clr;
  logic               win_v;
  logic [IDW-1:0]     win_id;
  logic [PW-1:0]      win_p;

  assign rise = irq_in & ~line_q;
  assign pend = (lvl_q & line_q) | (~lvl_q & pend_q);
  assign elig = pend & en_q & ~act_q;

  always_comb begin
    win_v  = 1'b0;
    win_id = '0;
    win_p  = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (elig[i] && (!win_v || prio_q[i*PW +: PW] < win_p)) begin
        win_v  = 1'b1;
        win_id = IDW'(i);
        win_p  = prio_q[i*PW +: PW];
      end
    end
  end

  assign ack_set  = (ack && win_v) ? (NUM_IRQ'(1) << win_id) : '0;
  assign done_clr = done ? (NUM_IRQ'(1) << done_id) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      pend_q <= '0;
      en_q   <= '0;
      lvl_q  <= '0;
      act_q  <= '0;
      prio_q <= '0;
    end else begin
      line_q <= irq_in;
      pend_q <= (pend_q & ~ack_set) | (rise & ~lvl_q);
      act_q  <= (act_q & ~done_clr) | ack_set;
      if (cfg_we && int'(cfg_idx) < NUM_IRQ) begin
        en_q[cfg_idx]  <= cfg_en;
        lvl_q[cfg_idx] <= cfg_level;
        prio_q[int'(cfg_idx)*PW +: PW] <= cfg_prio;
        if (cfg_level) pend_q[cfg_idx] <= 1'b0;
      end
    end
  end

  assign req_valid = win_v;
  assign req_id    = win_id;
  assign req_prio  = win_p;
  assign req_exc   = 8'(win_id) + 8'd16;

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int NUM_IRQ = 24,
  parameter int PW = 3,
  localparam int IDW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [IDW-1:0]     req_id,
  input logic [PW-1:0]      req_prio,
  input logic               ack,
  input logic               done,
  input logic [IDW-1:0]     done_id,
  input logic [NUM_IRQ-1:0] en_q,
  input logic [NUM_IRQ-1:0] act_q,
  input logic [NUM_IRQ*PW-1:0] prio_q
);

  AST_REQ_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> en_q[req_id]); // R4

  AST_REQ_NOT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !act_q[req_id]); // R8

  AST_ACK_ACTIVATES: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && req_valid) |=> act_q[$past(req_id)]); // R8

  AST_PRIO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_prio == prio_q[int'(req_id)*PW +: PW]); // R5

  AST_DONE_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (done && int'(done_id) < NUM_IRQ && !(ack && req_valid && req_id == done_id))
      |=> !act_q[$past(done_id)]); // R8

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NUM_IRQ(NUM_IRQ), .PW(PW)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
  .req_prio(req_prio), .ack(ack), .done(done), .done_id(done_id),
  .en_q(en_q), .act_q(act_q), .prio_q(prio_q)
);

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb_top;
  localparam int N = 8;
  localparam int PW = 3;
  localparam int IDW = 3;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] irq_in = '0;
  logic cfg_we = 0, cfg_en = 0, cfg_level = 0, ack = 0, done = 0;
  logic [IDW-1:0] cfg_idx = '0, done_id = '0;
  logic [PW-1:0] cfg_prio = '0;
  logic req_valid;
  logic [IDW-1:0] req_id;
  logic [PW-1:0] req_prio;
  logic [7:0] req_exc;

  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl #(.NUM_IRQ(N), .PW(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_en(cfg_en), .cfg_level(cfg_level), .cfg_prio(cfg_prio),
    .req_valid(req_valid), .req_id(req_id), .req_prio(req_prio), .req_exc(req_exc),
    .ack(ack), .done(done), .done_id(done_id));

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // -1 means no request; otherwise the presented line
  task automatic check_req(string tag, int exp_id, int exp_prio);
    int act;
    act = req_valid ? int'(req_id) : -1;
    check(tag, act, exp_id);
    if (exp_id >= 0 && req_valid) begin
      check(tag, int'(req_prio), exp_prio);
      check({tag, "/R7"}, int'(req_exc), exp_id + 16);
    end
  endtask

  task automatic cfg(int idx, bit en, bit lvl, int pr);
    cfg_we = 1; cfg_idx = IDW'(idx); cfg_en = en; cfg_level = lvl; cfg_prio = PW'(pr);
    step();
    cfg_we = 0;
  endtask

  task automatic do_ack();
    ack = 1; step(); ack = 0;
  endtask

  task automatic do_done(int idx);
    done = 1; done_id = IDW'(idx); step(); done = 0;
  endtask

  initial begin
    step(); step();
    check_req("R1 reset idle", -1, 0);
    rst_n = 1;
    step();
    check_req("R1 after reset", -1, 0);

    // R4: pulse on masked line 5 latches pending
    irq_in[5] = 1; step(); irq_in[5] = 0; step();
    check_req("R4 masked not requested", -1, 0);
    cfg(5, 1, 0, 2);
    check_req("R4 enabled pending line", 5, 2);
    step();
    check_req("R2 pulse pending held", 5, 2);
    do_ack();
    check_req("R8 acked line not requested", -1, 0);
    do_done(5);
    check_req("R2 pending cleared by ack", -1, 0);

    // R3 level line
    cfg(2, 1, 1, 1);
    irq_in[2] = 1; step();
    check_req("R3 level high requested", 2, 1);
    irq_in[2] = 0; step();
    check_req("R3 level low drops", -1, 0);
    irq_in[2] = 1; step();
    do_ack();
    check_req("R8 active level held off", -1, 0);
    do_done(2);
    check_req("R8 level re-requested", 2, 1);
    do_ack();
    irq_in[2] = 0; step();
    do_done(2);
    check_req("R8 level retired low", -1, 0);

    // R4 mask after pending
    irq_in[3] = 1; step(); irq_in[3] = 0;
    cfg(3, 1, 0, 4);
    check_req("R4 line3 requested", 3, 4);
    cfg(3, 0, 0, 4);
    check_req("R4 masking removes request", -1, 0);
    cfg(3, 1, 0, 4);
    check_req("R4 pending kept under mask", 3, 4);
    do_ack(); do_done(3);
    check_req("R4 line3 retired", -1, 0);

    // R5/R6 sweep: all lines level and enabled, priorities per round
    for (int k = 0; k < 4; k++) begin
      int pr[N];
      for (int i = 0; i < N; i++) begin
        pr[i] = (k < 2) ? ((i * 5 + k * 3) % 8) : ((i * (k + 1) + k) % 3);
        cfg(i, 1, 1, pr[i]);
      end
      for (int m = 0; m < 256; m++) begin
        int best, bp, ties;
        best = -1; bp = 0; ties = 0;
        for (int i = 0; i < N; i++)
          if (m[i]) begin
            if (best < 0 || pr[i] < bp) begin best = i; bp = pr[i]; ties = 0; end
            else if (pr[i] == bp) ties++;
          end
        irq_in = N'(m);
        step();
        check_req(ties > 0 ? "R6 tie lowest number" : "R5 lowest priority", best, bp);
      end
      irq_in = '0;
      step();
    end

    for (int i = 0; i < N; i++) cfg(i, 0, 0, 7);
    check_req("R1 all masked idle", -1, 0);

    // R9: edge and ack in same cycle
    cfg(6, 1, 0, 0);
    irq_in[6] = 1; step(); irq_in[6] = 0; step();
    check_req("R9 line6 requested", 6, 0);
    irq_in[6] = 1; ack = 1; step(); ack = 0; irq_in[6] = 0; step();
    check_req("R9 active line held off", -1, 0);
    do_done(6);
    check_req("R9 new edge survived ack", 6, 0);
    do_ack(); do_done(6);
    check_req("R9 finally idle", -1, 0);

    // R10: done on non-active lines
    irq_in[6] = 1; step(); irq_in[6] = 0; step();
    do_done(6);
    check_req("R10 done on pending line", 6, 0);
    do_done(1);
    check_req("R10 done on idle line", 6, 0);
    do_ack(); do_done(6);
    check_req("R10 cleanup idle", -1, 0);

    finished = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule